// File: doc/BRIEF.md
# Banked Multi-Queue Store

Six quadlet queues keep their contents in one shared single-port RAM of 4096 words of 32 bits. The RAM is cut into 64-word banks. Each queue owns a window of the RAM given by a first bank and a last bank, and software can move that window at run time. Producers push words into a queue and consumers pop them. Each queue reports whether it is full or empty and how many words it holds.

The RAM serves one access per cycle, so a fixed-priority arbiter picks one push or pop among the pending ones. A requester that loses the arbitration sees a stall flag for that cycle. The read and write pointers of each queue are 12-bit physical RAM addresses: the bank in the upper six bits and the word offset in the lower six. The pointers cycle through the queue's window.

The queues have fixed roles. Queues 0, 1 and 4 are receive queues. Queues 2, 3 and 5 are transmit queues. These roles matter only for arbitration.

Top module: `mfifo_shared`

## Requirements
- R1: After reset, the windows are banks 0–3, 4–7, 8–11, 12–15, 16–31 and 32–47 for queues 0 to 5. Register readback gives 0x00000003 for queue 0 and the matching values for the others. Every queue is empty with a count of 0, so queue 0 holds 256 words.
- R2: In a bounds register, the first bank sits in bits 13..8 and the last bank in bits 5..0. Every other bit reads back as zero, whatever value was written. The bounds are not checked against each other.
- R3: A queue's capacity is (last bank − first bank + 1) × 64 words. Full is high exactly when the count equals the capacity. A push into a full queue changes nothing and raises no stall.
- R4: Empty is high exactly when the count is zero. A pop from an empty queue returns no data and changes nothing.
- R5: Words leave a queue in the order they entered. A pointer at the last word of the last bank moves to word 0 of the first bank. Queues with disjoint windows never see each other's data.
- R6: Writing a queue's bounds register empties that queue. Both of its pointers move to the new first bank. Any push or pop to that queue in the same cycle is dropped.
- R7: At most one RAM access is granted per cycle, in this priority order: pops of transmit queues (2, 3, 5), then pushes of receive queues (0, 1, 4), then the other pushes by queue index, then the other pops by queue index. An effective request that is not granted raises that queue's stall bit.
- R8: Pop data and a one-hot valid flag for the served queue appear on the cycle after the pop is granted.
- R9: A queue's count rises by one for each granted push and falls by one for each granted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for a bounds register |
| cfg_sel_i | input | 3 | Selects the queue whose register is written or read |
| cfg_wdata_i | input | 32 | Bounds register write value |
| cfg_rdata_o | output | 32 | Readback of the selected bounds register |
| push_i | input | 6 | Push request, one bit per queue |
| push_data_i | input | 192 | Push words; queue i uses bits 32i+31..32i |
| pop_i | input | 6 | Pop request, one bit per queue |
| pop_valid_o | output | 6 | One-hot flag marking the queue whose pop data is on pop_data_o |
| pop_data_o | output | 32 | Popped word |
| full_o | output | 6 | Queue full flags |
| empty_o | output | 6 | Queue empty flags |
| count_o | output | 78 | Fill counts, 13 bits per queue; queue i uses bits 13i+12..13i |
| stall_o | output | 6 | Set when a queue's effective request was not granted this cycle |

## Verification
The queues are first filled to capacity and drained one at a time, first in the default reset windows and then in small two-bank windows. A full queue and an empty queue are each pushed or popped once more, which separates a correct full test from an off-by-one one. One queue is then cycled so that its pointers pass the last word of the window, and its words must still leave in order; this separates correct wrapping from a pointer that runs on into the next window. Finally, all 4096 combinations of the push and pop request vectors are applied in turn to partly filled queues. This sweep tells apart every pair of requesters in the grant order and catches a wrong stall, a lost count, or data delivered to the wrong queue.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;
  localparam int NUM_FIFO = 6;
  localparam int REG_W    = 32;
  localparam int CFG_BASE_LSB = 8;
  // 1 = transmit queue (pop gets top priority); 0 = receive queue
  localparam logic [NUM_FIFO-1:0] TX_MASK = 6'b101100;

  function automatic int rst_base(input int i);
    case (i)
      0: return 0;  1: return 4;  2: return 8;
      3: return 12; 4: return 16; default: return 32;
    endcase
  endfunction

  function automatic int rst_end(input int i);
    case (i)
      0: return 3;  1: return 7;  2: return 11;
      3: return 15; 4: return 31; default: return 47;
    endcase
  endfunction
endpackage

// File: rtl/mfifo_ram.sv
module mfifo_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mfifo_arb.sv
module mfifo_arb #(
  parameter int N = 6,
  parameter logic [N-1:0] TX = '0
) (
  input  logic [N-1:0] push_req_i,
  input  logic [N-1:0] pop_req_i,
  output logic [N-1:0] push_gnt_o,
  output logic [N-1:0] pop_gnt_o
);
  always_comb begin
    logic found;
    found      = 1'b0;
    push_gnt_o = '0;
    pop_gnt_o  = '0;
    for (int i = 0; i < N; i++)
      if (!found && TX[i] && pop_req_i[i]) begin pop_gnt_o[i] = 1'b1; found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && !TX[i] && push_req_i[i]) begin push_gnt_o[i] = 1'b1; found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && TX[i] && push_req_i[i]) begin push_gnt_o[i] = 1'b1; found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && !TX[i] && pop_req_i[i]) begin pop_gnt_o[i] = 1'b1; found = 1'b1; end
  end
endmodule

// File: rtl/mfifo_ctrl.sv
module mfifo_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int OFS_W    = 6,
  parameter int RST_BASE = 0,
  parameter int RST_END  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-OFS_W-1:0] cfg_base_i,
  input  logic [ADDR_W-OFS_W-1:0] cfg_end_i,
  input  logic                    push_req_i,
  input  logic                    pop_req_i,
  input  logic                    push_gnt_i,
  input  logic                    pop_gnt_i,
  output logic                    push_eff_o,
  output logic                    pop_eff_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  output logic [ADDR_W-OFS_W-1:0] base_o,
  output logic [ADDR_W-OFS_W-1:0] end_o,
  output logic [ADDR_W:0]         count_o,
  output logic                    full_o,
  output logic                    empty_o
);
  localparam int BANK_W = ADDR_W - OFS_W;
  localparam int CNT_W  = ADDR_W + 1;

  logic [BANK_W-1:0] base_q, end_q;
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0]  count_q, cap;
  logic [BANK_W:0]   span;

  assign span = {1'b0, end_q} - {1'b0, base_q} + 1'b1;
  assign cap  = {span, {OFS_W{1'b0}}};

  function automatic logic [ADDR_W-1:0] adv(input logic [ADDR_W-1:0] p);
    if (p == {end_q, {OFS_W{1'b1}}}) return {base_q, {OFS_W{1'b0}}};
    return p + 1'b1;
  endfunction

  assign full_o     = (count_q == cap);
  assign empty_o    = (count_q == '0);
  assign push_eff_o = push_req_i && !full_o && !cfg_we_i;
  assign pop_eff_o  = pop_req_i && !empty_o && !cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= BANK_W'(RST_BASE);
      end_q   <= BANK_W'(RST_END);
      wptr_q  <= {BANK_W'(RST_BASE), {OFS_W{1'b0}}};
      rptr_q  <= {BANK_W'(RST_BASE), {OFS_W{1'b0}}};
      count_q <= '0;
    end else if (cfg_we_i) begin
      base_q  <= cfg_base_i;
      end_q   <= cfg_end_i;
      wptr_q  <= {cfg_base_i, {OFS_W{1'b0}}};
      rptr_q  <= {cfg_base_i, {OFS_W{1'b0}}};
      count_q <= '0;
    end else if (push_gnt_i) begin
      wptr_q  <= adv(wptr_q);
      count_q <= count_q + 1'b1;
    end else if (pop_gnt_i) begin
      rptr_q  <= adv(rptr_q);
      count_q <= count_q - 1'b1;
    end
  end

  assign wr_addr_o = wptr_q;
  assign rd_addr_o = rptr_q;
  assign base_o    = base_q;
  assign end_o     = end_q;
  assign count_o   = count_q;
endmodule

// File: rtl/mfifo_shared.sv
module mfifo_shared
  import mfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [$clog2(NUM_FIFO)-1:0]  cfg_sel_i,
  input  logic [REG_W-1:0]             cfg_wdata_i,
  output logic [REG_W-1:0]             cfg_rdata_o,
  input  logic [NUM_FIFO-1:0]          push_i,
  input  logic [NUM_FIFO*DATA_W-1:0]   push_data_i,
  input  logic [NUM_FIFO-1:0]          pop_i,
  output logic [NUM_FIFO-1:0]          pop_valid_o,
  output logic [DATA_W-1:0]            pop_data_o,
  output logic [NUM_FIFO-1:0]          full_o,
  output logic [NUM_FIFO-1:0]          empty_o,
  output logic [NUM_FIFO*(ADDR_W+1)-1:0] count_o,
  output logic [NUM_FIFO-1:0]          stall_o
);
  localparam int N      = NUM_FIFO;
  localparam int SEL_W  = $clog2(N);
  localparam int BANK_W = ADDR_W - OFS_W;
  localparam int CNT_W  = ADDR_W + 1;
  localparam logic [REG_W-1:0] FIELD_MASK =
    (REG_W'((1 << BANK_W) - 1) << CFG_BASE_LSB) | REG_W'((1 << BANK_W) - 1);

  logic [N-1:0] push_eff, pop_eff, push_gnt, pop_gnt, cfg_hit;
  logic [ADDR_W-1:0] wr_addr [N];
  logic [ADDR_W-1:0] rd_addr [N];
  logic [BANK_W-1:0] base_b [N];
  logic [BANK_W-1:0] end_b [N];
  logic [REG_W-1:0]  reg_view [N];
  logic cfg_unused;

  assign cfg_unused = ^(cfg_wdata_i & ~FIELD_MASK);

  for (genvar i = 0; i < N; i++) begin : g_q
    assign cfg_hit[i] = cfg_we_i && (cfg_sel_i == SEL_W'(i));
    mfifo_ctrl #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W),
      .RST_BASE(rst_base(i)), .RST_END(rst_end(i))
    ) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cfg_we_i(cfg_hit[i]),
      .cfg_base_i(cfg_wdata_i[CFG_BASE_LSB +: BANK_W]),
      .cfg_end_i(cfg_wdata_i[BANK_W-1:0]),
      .push_req_i(push_i[i]), .pop_req_i(pop_i[i]),
      .push_gnt_i(push_gnt[i]), .pop_gnt_i(pop_gnt[i]),
      .push_eff_o(push_eff[i]), .pop_eff_o(pop_eff[i]),
      .wr_addr_o(wr_addr[i]), .rd_addr_o(rd_addr[i]),
      .base_o(base_b[i]), .end_o(end_b[i]),
      .count_o(count_o[i*CNT_W +: CNT_W]),
      .full_o(full_o[i]), .empty_o(empty_o[i])
    );
    assign reg_view[i] = (REG_W'(base_b[i]) << CFG_BASE_LSB) | REG_W'(end_b[i]);
  end

  mfifo_arb #(.N(N), .TX(TX_MASK)) u_arb (
    .push_req_i(push_eff), .pop_req_i(pop_eff),
    .push_gnt_o(push_gnt), .pop_gnt_o(pop_gnt)
  );

  assign stall_o = (push_eff & ~push_gnt) | (pop_eff & ~pop_gnt);

  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;

  always_comb begin
    ram_we = 1'b0; ram_re = 1'b0; ram_addr = '0; ram_wdata = '0;
    cfg_rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      if (push_gnt[i]) begin
        ram_we = 1'b1; ram_addr = wr_addr[i];
        ram_wdata = push_data_i[i*DATA_W +: DATA_W];
      end
      if (pop_gnt[i]) begin
        ram_re = 1'b1; ram_addr = rd_addr[i];
      end
      if (cfg_sel_i == SEL_W'(i)) cfg_rdata_o = reg_view[i];
    end
  end

  mfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .re_i(ram_re), .addr_i(ram_addr),
    .wdata_i(ram_wdata), .rdata_o(pop_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_valid_o <= '0;
    else         pop_valid_o <= pop_gnt;
  end
endmodule

// File: rtl/mfifo_shared_chk.sv
module mfifo_shared_chk
  import mfifo_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           cfg_we_i,
  input logic [$clog2(NUM_FIFO)-1:0]    cfg_sel_i,
  input logic [NUM_FIFO-1:0]            push_i,
  input logic [NUM_FIFO-1:0]            pop_i,
  input logic [NUM_FIFO-1:0]            pop_valid_o,
  input logic [NUM_FIFO-1:0]            full_o,
  input logic [NUM_FIFO-1:0]            empty_o,
  input logic [NUM_FIFO*(ADDR_W+1)-1:0] count_o,
  input logic [NUM_FIFO-1:0]            stall_o
);
  localparam int N     = NUM_FIFO;
  localparam int CNT_W = ADDR_W + 1;
  localparam int SEL_W = $clog2(N);

  logic [N-1:0] hit, tx_pop_eff;
  for (genvar i = 0; i < N; i++) begin : g_h
    assign hit[i] = cfg_we_i && (cfg_sel_i == SEL_W'(i));
  end
  assign tx_pop_eff = pop_i & ~empty_o & TX_MASK & ~hit;

  assert_one_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_valid_o));

  assert_txpop_served_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_eff != '0) |=> ((pop_valid_o & $past(tx_pop_eff)) != '0));

  for (genvar i = 0; i < N; i++) begin : g_a
    assert_flags_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(full_o[i] && empty_o[i]));

    assert_full_push_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o[i] && !pop_i[i] && !hit[i]) |=> full_o[i]);

    assert_empty_pop_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o[i] && !push_i[i]) |=> (empty_o[i] && !pop_valid_o[i]));

    assert_cfg_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[i] |=> (empty_o[i] && count_o[i*CNT_W +: CNT_W] == '0));

    assert_stall_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o[i] |-> ((push_i[i] && !full_o[i]) || (pop_i[i] && !empty_o[i])));

    assert_pop_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_valid_o[i] |-> $past(pop_i[i] && !empty_o[i] && !hit[i]));

    assert_count_up_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i[i] && !full_o[i] && !stall_o[i] && !hit[i]) |=>
      count_o[i*CNT_W +: CNT_W] == $past(count_o[i*CNT_W +: CNT_W]) + 1'b1);
  end
endmodule

bind mfifo_shared mfifo_shared_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
  .push_i(push_i), .pop_i(pop_i), .pop_valid_o(pop_valid_o),
  .full_o(full_o), .empty_o(empty_o), .count_o(count_o), .stall_o(stall_o)
);

// File: tb/mfifo_shared_bench.sv
`timescale 1ns/1ps
module mfifo_shared_bench;
  localparam int N = 6, DW = 32, CW = 13;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [N-1:0] push = '0, pop = '0, pop_valid, full, empty, stall;
  logic [N*DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic [N*CW-1:0] count;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mq [N][$];
  int cap [N];

  always #4 clk = ~clk;

  mfifo_shared u_mfifo_shared (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .push_i(push),
    .push_data_i(push_data), .pop_i(pop), .pop_valid_o(pop_valid),
    .pop_data_o(pop_data), .full_o(full), .empty_o(empty), .count_o(count),
    .stall_o(stall)
  );

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // grant order from R7
  function automatic int winner(logic [N-1:0] pe, logic [N-1:0] qe);
    int txo[3] = '{2, 3, 5};
    int rxo[3] = '{0, 1, 4};
    foreach (txo[j]) if (qe[txo[j]]) return N + txo[j];
    foreach (rxo[j]) if (pe[rxo[j]]) return rxo[j];
    for (int i = 0; i < N; i++) if (pe[i]) return i;
    for (int i = 0; i < N; i++) if (qe[i]) return N + i;
    return -1;
  endfunction

  task automatic check_flags();
    logic [N-1:0] fe, ee;
    for (int i = 0; i < N; i++) begin
      chk("R9 count", 64'(count[i*CW +: CW]), 64'(mq[i].size()));
      fe[i] = (mq[i].size() == cap[i]);
      ee[i] = (mq[i].size() == 0);
    end
    chk("R3/R4 full,empty", {full, empty}, {fe, ee});
  endtask

  task automatic step(logic [N-1:0] pu, logic [N-1:0] po, int tag);
    logic [N-1:0] pe, qe, st;
    logic [31:0] d [N];
    logic [31:0] exp_d;
    int w;
    for (int i = 0; i < N; i++) begin
      pe[i] = pu[i] && (mq[i].size() < cap[i]);
      qe[i] = po[i] && (mq[i].size() > 0);
      d[i]  = {tag[23:0], 8'(i)};
    end
    w = winner(pe, qe);
    for (int i = 0; i < N; i++)
      st[i] = (pe[i] && w != i) || (qe[i] && w != N + i);
    @(negedge clk);
    push = pu; pop = po;
    for (int i = 0; i < N; i++) push_data[i*DW +: DW] = d[i];
    #1 chk("R7 stall", 64'(stall), 64'(st));
    @(posedge clk); #1;
    exp_d = '0;
    if (w >= 0 && w < N) mq[w].push_back(d[w]);
    if (w >= N) exp_d = mq[w-N].pop_front();
    chk("R8 pop_valid", 64'(pop_valid), (w >= N) ? 64'(1) << (w - N) : 64'(0));
    if (w >= N) chk("R5 pop_data", 64'(pop_data), 64'(exp_d));
    check_flags();
  endtask

  task automatic cfg(int k, logic [31:0] wv);
    int b, e;
    @(negedge clk);
    push = '0; pop = '0;
    cfg_we = 1'b1; cfg_sel = 3'(k); cfg_wdata = wv;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    b = int'((wv >> 8) & 32'h3f); e = int'(wv & 32'h3f);
    mq[k].delete();
    cap[k] = (e - b + 1) * 64;
    #1 chk("R2 readback", 64'(cfg_rdata), 64'((b << 8) | e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int rb[N] = '{0, 4, 8, 12, 16, 32};
    int re[N] = '{3, 7, 11, 15, 31, 47};
    for (int i = 0; i < N; i++) cap[i] = (re[i] - rb[i] + 1) * 64;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset windows and register values
    for (int k = 0; k < N; k++) begin
      @(negedge clk) cfg_sel = 3'(k);
      #1 chk("R1 reset reg", 64'(cfg_rdata), 64'((rb[k] << 8) | re[k]));
    end
    chk("R1 empty", 64'(empty), 64'h3f);
    chk("R1 full", 64'(full), 64'h0);
    check_flags();

    // R1/R3 default queue 0 holds 256, extra push ignored
    for (int n = 0; n < 257; n++) step(6'b000001, 6'b0, n);
    chk("R3 full at cap", 64'(full[0]), 64'(1));
    chk("R3 count at cap", 64'(count[0 +: CW]), 64'(256));
    // R4 extra pop ignored
    for (int n = 0; n < 257; n++) step(6'b0, 6'b000001, n);
    chk("R4 empty after drain", 64'(empty[0]), 64'(1));

    // R2 field placement, other bits zero
    cfg(5, 32'hDEADE5F7);
    chk("R2 field placement", 64'(cfg_rdata), 64'h2537);

    // two-bank windows, disjoint
    for (int k = 0; k < N; k++) cfg(k, 32'(((8 * k) << 8) | (8 * k + 1)));
    for (int k = 0; k < N; k++)
      for (int n = 0; n < 129; n++) step(6'(1 << k), 6'b0, 1000 + n);
    chk("R3 all full", 64'(full), 64'h3f);
    for (int k = 0; k < N; k++)
      for (int n = 0; n < 129; n++) step(6'b0, 6'(1 << k), n);

    // R5 wrap inside the window
    for (int n = 0; n < 100; n++) step(6'b000001, 6'b0, 2000 + n);
    for (int n = 0; n < 100; n++) step(6'b0, 6'b000001, n);
    for (int n = 0; n < 128; n++) step(6'b000001, 6'b0, 3000 + n);
    for (int n = 0; n < 128; n++) step(6'b0, 6'b000001, n);

    // R6 reprogramming empties the queue
    for (int n = 0; n < 5; n++) step(6'b000010, 6'b0, 4000 + n);
    cfg(1, 32'h0809);
    chk("R6 count cleared", 64'(count[CW +: CW]), 64'(0));
    chk("R6 empty", 64'(empty[1]), 64'(1));
    step(6'b0, 6'b000010, 0);
    step(6'b000010, 6'b0, 4100);
    step(6'b0, 6'b000010, 0);

    // R7 sweep of all request combinations
    for (int k = 0; k < N; k++)
      for (int n = 0; n < 3; n++) step(6'(1 << k), 6'b0, 5000 + n);
    for (int p = 0; p < 4096; p++) step(p[5:0], p[11:6], 8192 + p);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule